// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

A 24-stage binary divider for periodic timing. It advances by one on each accepted count event. The event is a single-cycle `cnt_en` pulse that stands in for an external input clock, and the whole chain updates on one edge of the system clock. The timing output comes from one stage of the upper sixteen, picked by a 4-bit code. A bypass control can skip the lowest eight stages, so each count event drives stage 9 directly. This shortens the reachable periods by a factor of 256.

Two synchronous controls load the whole chain: a clear, which wins over a preset, and a preset. A count-inhibit control freezes the chain. When bypass, preset and clear are all high together, the chain splits into three independent 8-bit counters that all advance on the count event. This lets each section be exercised without waiting through the full carry path. An optional digital one-shot turns each rising edge of the selected stage into a pulse lasting a programmable number of system clocks. When the one-shot is disabled, the selected stage drives the output directly.

Top module: `tap_timer`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, every stage reads 0 and `tap_out` is 0.
- R2: With bypass at 0 and no clear or preset, each accepted event (`cnt_en`=1 and `hold`=0) adds 1 modulo 2^24 to `stage_q` at the next clock edge.
- R3: With bypass at 1 and no clear or preset, an accepted event leaves `stage_q[7:0]` unchanged and adds 1 modulo 2^16 to `stage_q[23:8]`, so `stage_q[8]` toggles on every event.
- R4: With `hold`=1 outside the split mode and with no clear or preset, `stage_q` keeps its value whatever `cnt_en` does.
- R5: Outside the split mode, `clr`=1 makes `stage_q` all zeros at the next edge. `preset`=1 with `clr`=0 makes it all ones. Clear wins over preset.
- R6: With `bypass`, `preset` and `clr` all 1, each of the sections `stage_q[7:0]`, `[15:8]` and `[23:16]` adds 1 modulo 256 per accepted event. No carry passes between sections and no load takes place.
- R7: The selected stage is `stage_q[8+sel]`: code 0 picks stage 9 (bit 8) and code 15 picks stage 24 (bit 23). With `os_en`=0, `tap_out` equals that bit in the same cycle.
- R8: With `os_en`=1, a 0-to-1 change of the selected bit raises `tap_out` one clock later and holds it high for `os_width` clocks. A width of 0 acts as 1. Rising edges are detected by comparing the bit selected now with the bit sampled one clock earlier.
- R9: A new rising edge while a pulse is running reloads the full width, so the pulse is extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count event, one cycle per input tick |
| hold | input | 1 | Count inhibit |
| preset | input | 1 | Load all ones |
| clr | input | 1 | Load all zeros; wins over preset |
| bypass | input | 1 | Skip the lowest eight stages |
| sel | input | 4 | Tap code, stage 9 + code |
| os_en | input | 1 | Enable the one-shot on the output |
| os_width | input | 8 | One-shot pulse length in clocks |
| tap_out | output | 1 | Timing output |
| stage_q | output | 24 | State of all stages |

## Verification
Several faults would show up first at the section boundaries. A carry that is lost or added between bits 7/8 or 15/16 would send the upper stages off by 256 or 65536 after a wrap. In the split mode, a carry that leaks across sections would move a neighbour on every wrap. With bypass set, a lower section that keeps counting would break the toggle of stage 9 on each event. The tap sweep covers all sixteen codes with bypass on and off, so an off-by-one tap index would show the wrong division ratio. On the one-shot side, the bench targets a zero width, edges caused by loading all ones, and retriggers during a running pulse. A design that ignored a retrigger would drop the output early.

// File: rtl/tap_timer_pkg.sv
// Shared constants and the chain operating mode for the tap-select timer.
package tap_timer_pkg;
    localparam int SEC_W_DEF = 8;   // stages per section
    localparam int N_SEC_DEF = 3;   // sections in the chain
    localparam int PW_W_DEF  = 8;   // one-shot width field

    typedef enum logic [1:0] {
        MODE_FULL   = 2'd0,  // whole chain carries
        MODE_SKIP   = 2'd1,  // lowest section skipped
        MODE_SPLIT  = 2'd2   // sections count independently
    } chain_mode_e;
endpackage

// File: rtl/tap_timer_section.sv
// One section of the binary chain.
// Assumes the loads are already prioritised by the caller; clear wins here too.
// The carry is combinational so that a whole chain settles in one clock.
module tap_timer_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_zero,
    input  logic         ld_ones,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         carry
);
    // State update: reset, loads, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (ld_zero) q <= '0;
        else if (ld_ones) q <= '1;
        else if (inc)     q <= q + 1'b1;
    end

    // Carry into the next section when this one wraps.
    always_comb carry = inc & (&q);
endmodule

// File: rtl/tap_timer_oneshot.sv
// Digital one-shot: a rising edge on trig starts a pulse of `width` clocks
// (0 acts as 1) and a new edge reloads it. Assumes trig is a registered level.
module tap_timer_oneshot #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            trig,
    input  logic [PW_W-1:0] width,
    output logic            pulse
);
    logic            trig_d;
    logic [PW_W-1:0] remain;
    logic            rise;
    logic [PW_W-1:0] load_val;

    // Edge detect and reload value.
    always_comb begin
        rise     = trig & ~trig_d;
        load_val = (width == '0) ? PW_W'(1) : width;
    end

    // Previous trigger sample.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_d <= 1'b0;
        else        trig_d <= trig;
    end

    // Pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (!enable)      remain <= '0;
        else if (rise)         remain <= load_val;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    // Output is high while time remains.
    always_comb pulse = (remain != '0);
endmodule

// File: rtl/tap_timer.sv
// Tap-select binary timer: a chain of N_SEC sections of SEC_W stages, a tap
// picked from all stages above the lowest section, and an optional one-shot.
// Assumes cnt_en is a one-cycle pulse per input tick, synchronous to clk.
module tap_timer
    import tap_timer_pkg::*;
#(
    parameter int SEC_W = SEC_W_DEF,
    parameter int N_SEC = N_SEC_DEF,
    parameter int PW_W  = PW_W_DEF,
    localparam int CHAIN_W = SEC_W * N_SEC,
    localparam int TAP_N   = CHAIN_W - SEC_W,
    localparam int SEL_W   = $clog2(TAP_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    input  logic               hold,
    input  logic               preset,
    input  logic               clr,
    input  logic               bypass,
    input  logic [SEL_W-1:0]   sel,
    input  logic               os_en,
    input  logic [PW_W-1:0]    os_width,
    output logic               tap_out,
    output logic [CHAIN_W-1:0] stage_q
);
    chain_mode_e      mode;
    logic             step;
    logic             ld_zero;
    logic             ld_ones;
    logic [N_SEC-1:0] sec_inc;
    logic [N_SEC-1:0] sec_carry;
    logic [TAP_N-1:0] upper;
    logic             tap_bit;
    logic             os_pulse;

    // Mode decode and load priority.
    always_comb begin
        if (bypass & preset & clr) mode = MODE_SPLIT;
        else if (bypass)           mode = MODE_SKIP;
        else                       mode = MODE_FULL;
        step    = cnt_en & ~hold;
        ld_zero = clr & (mode != MODE_SPLIT);
        ld_ones = preset & ~clr;
    end

    // Per-section increment routing.
    generate
        for (genvar i = 0; i < N_SEC; i++) begin : g_sec
            if (i == 0) begin : g_low
                always_comb sec_inc[i] = step & (mode != MODE_SKIP);
            end else if (i == 1) begin : g_first_up
                always_comb sec_inc[i] = (mode == MODE_FULL) ? sec_carry[i-1] : step;
            end else begin : g_rest
                always_comb sec_inc[i] = (mode == MODE_SPLIT) ? step : sec_carry[i-1];
            end

            tap_timer_section #(.W(SEC_W)) u_sec (
                .clk     (clk),
                .rst_n   (rst_n),
                .ld_zero (ld_zero),
                .ld_ones (ld_ones),
                .inc     (sec_inc[i]),
                .q       (stage_q[i*SEC_W +: SEC_W]),
                .carry   (sec_carry[i])
            );
        end
    endgenerate

    // Tap select from the stages above the lowest section.
    always_comb begin
        upper   = stage_q[CHAIN_W-1:SEC_W];
        tap_bit = upper[sel];
    end

    tap_timer_oneshot #(.PW_W(PW_W)) u_os (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (os_en),
        .trig   (tap_bit),
        .width  (os_width),
        .pulse  (os_pulse)
    );

    // Output source: one-shot or direct tap.
    always_comb tap_out = os_en ? os_pulse : tap_bit;
endmodule

// File: rtl/tap_timer_chk.sv
// Protocol checks on the tap timer ports, bound to every instance.
module tap_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cnt_en,
    input logic        hold,
    input logic        preset,
    input logic        clr,
    input logic        bypass,
    input logic [23:0] stage_q
);
    logic split;
    always_comb split = bypass & preset & clr;

    // R2
    full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !clr && !preset && cnt_en && !hold) |=> (stage_q == $past(stage_q) + 24'd1));

    // R3
    skip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !clr && !preset && cnt_en && !hold) |=>
        (stage_q[7:0] == $past(stage_q[7:0]) && stage_q[23:8] == $past(stage_q[23:8]) + 16'd1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr && !preset) |=> $stable(stage_q));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !split) |=> (stage_q == 24'd0));

    // R5
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !clr) |=> (stage_q == 24'hFF_FFFF));

    // R6
    split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split && cnt_en && !hold) |=>
        (stage_q[7:0] == $past(stage_q[7:0]) + 8'd1 &&
         stage_q[15:8] == $past(stage_q[15:8]) + 8'd1 &&
         stage_q[23:16] == $past(stage_q[23:16]) + 8'd1));
endmodule

bind tap_timer tap_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .hold    (hold),
    .preset  (preset),
    .clr     (clr),
    .bypass  (bypass),
    .stage_q (stage_q)
);

// File: tb/tap_timer_tb_top.sv
module tap_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_en, hold, preset, clr, bypass, os_en;
    logic [3:0]  sel;
    logic [7:0]  os_width;
    logic        tap_out;
    logic [23:0] stage_q;

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R1";

    // reference state
    logic [23:0] m_q    = '0;
    logic        m_prev = 1'b0;
    int          m_cnt  = 0;

    always #5 clk = ~clk;

    tap_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hold(hold), .preset(preset),
        .clr(clr), .bypass(bypass), .sel(sel), .os_en(os_en), .os_width(os_width),
        .tap_out(tap_out), .stage_q(stage_q)
    );

    function automatic logic [23:0] next_q(logic [23:0] q, logic en, logic inh,
                                           logic st, logic cl, logic byp);
        logic [23:0] r = q;
        logic stp = en & ~inh;
        if (byp & st & cl) begin
            if (stp) begin
                r[7:0]   = q[7:0] + 8'd1;
                r[15:8]  = q[15:8] + 8'd1;
                r[23:16] = q[23:16] + 8'd1;
            end
        end else if (cl)  r = '0;
        else if (st)      r = '1;
        else if (stp) begin
            if (byp) r[23:8] = q[23:8] + 16'd1;
            else     r = q + 24'd1;
        end
        return r;
    endfunction

    function automatic logic exp_tap();
        return os_en ? (m_cnt != 0) : m_q[8 + int'(sel)];
    endfunction

    task automatic chk(input logic ok, input string what, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(stage_q === m_q, "stage_q", stage_q, m_q);
        chk(tap_out === exp_tap(), "tap_out", {23'd0, tap_out}, {23'd0, exp_tap()});
    endtask

    // Drive one cycle of inputs at a negedge, advance the model, check at the next negedge.
    task automatic cyc(input logic en, input logic inh, input logic st, input logic cl,
                       input logic byp, input logic [3:0] s, input logic oe, input logic [7:0] w);
        logic rbit;
        cnt_en = en; hold = inh; preset = st; clr = cl; bypass = byp;
        sel = s; os_en = oe; os_width = w;
        rbit = m_q[8 + int'(s)];
        if (!oe)                   m_cnt = 0;
        else if (rbit && !m_prev)  m_cnt = (w == 8'd0) ? 1 : int'(w);
        else if (m_cnt != 0)       m_cnt = m_cnt - 1;
        m_prev = rbit;
        m_q = next_q(m_q, en, inh, st, cl, byp);
        @(negedge clk);
        check_outputs();
    endtask

    initial begin : watchdog
        #1_900_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired in phase %s", tag);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cnt_en = 0; hold = 0; preset = 0; clr = 0; bypass = 0;
        sel = 0; os_en = 0; os_width = 0;
        // R1: reset state, even with a count requested
        repeat (3) @(negedge clk);
        cnt_en = 1'b1;
        @(negedge clk);
        chk(stage_q === 24'd0, "stage_q during reset", stage_q, 24'd0);
        chk(tap_out === 1'b0, "tap_out during reset", {23'd0, tap_out}, 24'd0);
        cnt_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs();

        tag = "R2"; // full chain count, including a wrap from all ones
        for (int i = 0; i < 3000; i++)
            cyc($urandom_range(0, 3) != 0, 0, 0, 0, 0, 4'($urandom), 0, 0);
        cyc(0, 0, 1, 0, 0, 4'd15, 0, 0);
        for (int i = 0; i < 600; i++)
            cyc(1, 0, 0, 0, 0, 4'($urandom), 0, 0);

        tag = "R3"; // bypass: stage 9 toggles each event, low section frozen
        for (int i = 0; i < 4000; i++)
            cyc($urandom_range(0, 1), 0, 0, 0, 1, 4'($urandom_range(0, 3)), 0, 0);

        tag = "R4"; // inhibit holds the chain
        for (int i = 0; i < 600; i++)
            cyc(1, $urandom_range(0, 1), 0, 0, $urandom_range(0, 1), 4'($urandom), 0, 0);

        tag = "R5"; // loads and their priority
        cyc(1, 0, 1, 1, 0, 4'd0, 0, 0);
        cyc(1, 0, 1, 0, 0, 4'd15, 0, 0);
        for (int i = 0; i < 600; i++) begin
            logic st = ($urandom_range(0, 7) == 0);
            logic cl = ($urandom_range(0, 7) == 0);
            cyc($urandom_range(0, 1), 0, st, cl, 0, 4'($urandom), 0, 0);
        end

        tag = "R6"; // split mode, start from ones so every section wraps together
        cyc(0, 0, 1, 0, 0, 4'd0, 0, 0);
        for (int i = 0; i < 800; i++)
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0, 1, 1, 1, 4'($urandom), 0, 0);

        tag = "R7"; // every tap code, bypass on and off
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 16; s++)
                for (int i = 0; i < 300; i++)
                    cyc(1, 0, 0, 0, 1'(b), 4'(s), 0, 0);

        tag = "R8"; // one-shot with random widths, zero included
        for (int i = 0; i < 5000; i++) begin
            logic ld = ($urandom_range(0, 60) == 0);
            cyc($urandom_range(0, 1), 0, ld & $urandom_range(0, 1), ld, 1,
                4'($urandom_range(0, 1)), 1, 8'($urandom_range(0, 12)));
        end

        tag = "R9"; // retrigger during a running pulse
        cyc(0, 0, 0, 1, 0, 4'd0, 1, 8'd6);
        cyc(0, 0, 1, 0, 0, 4'd0, 1, 8'd6);
        cyc(0, 0, 0, 0, 0, 4'd0, 1, 8'd6);
        cyc(0, 0, 0, 0, 0, 4'd0, 1, 8'd6);
        cyc(0, 0, 0, 1, 0, 4'd0, 1, 8'd6);
        cyc(0, 0, 1, 0, 0, 4'd0, 1, 8'd6);
        for (int i = 0; i < 12; i++)
            cyc(0, 0, 0, 0, 0, 4'd0, 1, 8'd6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule